// File: doc/BRIEF.md
# Signed Two's Complement Array Multiplier

This block multiplies two WIDTH-bit two's complement operands and returns their full 2·WIDTH-bit signed product. It is built as a regular grid of identical cells. Each cell forms one partial-product bit from an operand bit pair and adds it into a running carry-save sum. The partial-product bits whose weight would be negative are entered complemented (NAND in place of AND), and two constant ones are folded into the array. As a result the grid only ever adds positive bits, and it needs neither sign extension nor a final negation. A ripple-carry row below the grid resolves the last sum and carry vectors into the upper half of the product.

A build-time switch selects one of two forms. In the first, the whole array is combinational and the valid flag passes straight through. In the second, a register stage sits between each pair of adjacent cell rows. The operands, the partial sums and carries, and the low product bits already resolved all travel together through these stages, so each row still sees the operand bits that belong to its own pair. The valid flag follows the same path and is delayed by the same number of cycles.

Top module: `bw_mult`

## Requirements
- R1: For every pair of operands, `p` equals the two's complement product of `a` and `x`, taken as signed WIDTH-bit values and given as 2·WIDTH bits.
- R2: The extreme operands give exact results. For WIDTH=5, −16×−16 gives 256 (0x100), and −16×15 and 15×−16 both give −240 (0x310).
- R3: When either operand is zero, `p` is zero.
- R4: With PIPELINED=0, `validOut` equals `validIn` in the same cycle, and `p` is the product of the operands present in that cycle.
- R5: With PIPELINED=1, each cycle in which `validIn` is high produces exactly one cycle of `validOut` WIDTH−1 cycles later, carrying that pair's product. This holds for back-to-back pairs and for pairs separated by idle cycles.
- R6: While `rstN` is low, and after its release until the first accepted pair reaches the output, `validOut` is low.
- R7: Operands presented while `validIn` is low produce no `validOut` pulse.
- R8: For a nonzero product, the top bit of `p` equals the exclusive-or of the top bits of `a` and `x`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the pipeline stages and the valid delay line |
| rstN | input | 1 | Asynchronous active-low reset of the valid delay line |
| validIn | input | 1 | High when `a` and `x` carry a pair to multiply |
| a | input | WIDTH | Multiplicand, two's complement |
| x | input | WIDTH | Multiplier, two's complement |
| validOut | output | 1 | High when `p` holds the product of an accepted pair |
| p | output | 2·WIDTH | Signed product, two's complement |

## Verification
The bench builds the block twice with WIDTH=5: once with PIPELINED=1, which gives a four-cycle latency, and once with PIPELINED=0. This lets one run check both the registered valid path and the pass-through valid path against the same stream of operands. Because the operand width is five bits, all 1024 operand pairs can be swept in every instance. The sweep covers both NAND-entered sign rows, both injected constants and the minimum-times-minimum product. Added runs with idle cycles between pairs test that operands presented while `validIn` is low are never released.

// File: rtl/bw_mult_pkg.sv
package bw_mult_pkg;

  typedef struct packed {
    logic launch;
    logic outValid;
  } mult_strobe_t;

  function automatic bit ppInverted(int row, int col, int width);
    return (row == width - 1) != (col == width - 1);
  endfunction

endpackage

// File: rtl/bw_pp_cell.sv
module bw_pp_cell #(
  parameter bit INVERT = 1'b0
) (
  input  logic aBit,
  input  logic xBit,
  input  logic sumIn,
  input  logic carryIn,
  output logic sumOut,
  output logic carryOut
);
  logic ppBit;

  assign ppBit    = INVERT ? ~(aBit & xBit) : (aBit & xBit);
  assign sumOut   = ppBit ^ sumIn ^ carryIn;
  assign carryOut = (ppBit & sumIn) | (ppBit & carryIn) | (sumIn & carryIn);
endmodule

// File: rtl/bw_mult_ctrl.sv
module bw_mult_ctrl
  import bw_mult_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         validIn,
  output mult_strobe_t strobe
);
  if (LATENCY > 0) begin : g_pipe
    logic [LATENCY-1:0] vldLine;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) vldLine <= '0;
      else       vldLine <= (vldLine << 1) | LATENCY'(validIn);
    end

    always_comb begin
      strobe.launch   = validIn;
      strobe.outValid = vldLine[LATENCY-1];
    end
  end else begin : g_comb
    always_comb begin
      strobe.launch   = validIn;
      strobe.outValid = validIn;
    end
  end
endmodule

// File: rtl/bw_mult_dp.sv
module bw_mult_dp
  import bw_mult_pkg::*;
#(
  parameter int WIDTH     = 5,
  parameter bit PIPELINED = 1'b1
) (
  input  logic               clk,
  input  mult_strobe_t       strobe,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   x,
  output logic [2*WIDTH-1:0] product
);
  localparam int ROWS = WIDTH;

  // Row inputs (operands, sums, carries, resolved low bits)
  logic [WIDTH-1:0] inA   [ROWS];
  logic [WIDTH-1:0] inX   [ROWS];
  logic [WIDTH-1:0] inSum [ROWS];
  logic [WIDTH-1:0] inCar [ROWS];
  logic [WIDTH-1:0] inLow [ROWS];
  // Row outputs
  wire  [WIDTH-1:0] outSum [ROWS];
  wire  [WIDTH-1:0] outCar [ROWS];
  wire  [WIDTH-1:0] outLow [ROWS];

  assign inA[0]   = a;
  assign inX[0]   = x;
  assign inSum[0] = '0;
  assign inCar[0] = '0;
  assign inLow[0] = '0;

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    for (genvar j = 0; j < WIDTH; j++) begin : g_col
      wire cellSumIn;
      wire cellCarIn;
      if (i == 0) begin : g_first
        assign cellSumIn = 1'b0;
        assign cellCarIn = 1'b0;
      end else if (j < WIDTH - 1) begin : g_inner
        assign cellSumIn = inSum[i][j+1];
        assign cellCarIn = inCar[i][j];
      end else begin : g_edge
        // constant one of weight WIDTH enters on row 1
        assign cellSumIn = (i == 1);
        assign cellCarIn = inCar[i][j];
      end

      bw_pp_cell #(.INVERT(ppInverted(i, j, WIDTH))) u_cell (
        .aBit    (inA[i][j]),
        .xBit    (inX[i][i]),
        .sumIn   (cellSumIn),
        .carryIn (cellCarIn),
        .sumOut  (outSum[i][j]),
        .carryOut(outCar[i][j])
      );
    end

    assign outLow[i] = inLow[i] | (WIDTH'(outSum[i][0]) << i);
  end

  for (genvar b = 0; b < ROWS - 1; b++) begin : g_bound
    if (PIPELINED) begin : g_reg
      always_ff @(posedge clk) begin
        if (b != 0 || strobe.launch) begin
          inA[b+1]   <= inA[b];
          inX[b+1]   <= inX[b];
          inSum[b+1] <= outSum[b];
          inCar[b+1] <= outCar[b];
          inLow[b+1] <= outLow[b];
        end
      end
    end else begin : g_wire
      assign inA[b+1]   = inA[b];
      assign inX[b+1]   = inX[b];
      assign inSum[b+1] = outSum[b];
      assign inCar[b+1] = outCar[b];
      assign inLow[b+1] = outLow[b];
    end
  end

  // Final ripple row; constant one of weight 2*WIDTH-1 sits in the top slot
  logic [WIDTH-1:0] rippleA;
  logic [WIDTH-1:0] rippleB;
  logic [WIDTH-1:0] upperBits;

  assign rippleA = {1'b1, outSum[ROWS-1][WIDTH-1:1]};
  assign rippleB = outCar[ROWS-1];

  always_comb begin
    logic rc;
    rc = 1'b0;
    for (int k = 0; k < WIDTH; k++) begin
      upperBits[k] = rippleA[k] ^ rippleB[k] ^ rc;
      rc = (rippleA[k] & rippleB[k]) | (rc & (rippleA[k] ^ rippleB[k]));
    end
  end

  assign product = {upperBits, outLow[ROWS-1]};
endmodule

// File: rtl/bw_mult.sv
module bw_mult
  import bw_mult_pkg::*;
#(
  parameter int WIDTH     = 5,
  parameter bit PIPELINED = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               validIn,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   x,
  output logic               validOut,
  output logic [2*WIDTH-1:0] p
);
  localparam int LATENCY = PIPELINED ? WIDTH - 1 : 0;

  mult_strobe_t strobe;

  bw_mult_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .validIn(validIn),
    .strobe (strobe)
  );

  bw_mult_dp #(.WIDTH(WIDTH), .PIPELINED(PIPELINED)) u_dp (
    .clk    (clk),
    .strobe (strobe),
    .a      (a),
    .x      (x),
    .product(p)
  );

  assign validOut = strobe.outValid;
endmodule

// File: rtl/bw_mult_checker.sv
module bw_mult_checker #(
  parameter int WIDTH   = 5,
  parameter int LATENCY = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               validIn,
  input logic [WIDTH-1:0]   a,
  input logic [WIDTH-1:0]   x,
  input logic               validOut,
  input logic [2*WIDTH-1:0] p
);
  localparam int PW = 2 * WIDTH;

  logic             vDly [LATENCY+1];
  logic [WIDTH-1:0] aDly [LATENCY+1];
  logic [WIDTH-1:0] xDly [LATENCY+1];

  assign vDly[0] = validIn;
  assign aDly[0] = a;
  assign xDly[0] = x;

  for (genvar k = 1; k <= LATENCY; k++) begin : g_dly
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) vDly[k] <= 1'b0;
      else       vDly[k] <= vDly[k-1];
    end
    always_ff @(posedge clk) begin
      aDly[k] <= aDly[k-1];
      xDly[k] <= xDly[k-1];
    end
  end

  logic signed [PW-1:0] aExt, xExt, refProd;
  logic                 aZero, xZero, aMin, xMin;

  assign aExt    = PW'($signed(aDly[LATENCY]));
  assign xExt    = PW'($signed(xDly[LATENCY]));
  assign refProd = aExt * xExt;
  assign aZero   = (aDly[LATENCY] == '0);
  assign xZero   = (xDly[LATENCY] == '0);
  assign aMin    = (aDly[LATENCY] == {1'b1, {(WIDTH-1){1'b0}}});
  assign xMin    = (xDly[LATENCY] == {1'b1, {(WIDTH-1){1'b0}}});

  // R5 (and R4 when LATENCY is zero, R7 for idle inputs)
  assert_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    validOut == vDly[LATENCY]);

  assert_product_R1: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> (p == refProd));

  assert_extreme_R2: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && aMin && xMin) |-> (p == (PW'(1) << (PW - 2))));

  assert_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && (aZero || xZero)) |-> (p == '0));

  assert_sign_R8: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && !aZero && !xZero) |->
      (p[PW-1] == (aDly[LATENCY][WIDTH-1] ^ xDly[LATENCY][WIDTH-1])));

  if (LATENCY > 0) begin : g_rst
    assert_reset_R6: assert property (@(posedge clk) !rstN |-> !validOut);
  end
endmodule

bind bw_mult bw_mult_checker #(.WIDTH(WIDTH), .LATENCY(LATENCY)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .validIn (validIn),
  .a       (a),
  .x       (x),
  .validOut(validOut),
  .p       (p)
);

// File: tb/bw_mult_test.sv
module bw_mult_test;
  localparam int N   = 5;
  localparam int PW  = 2 * N;
  localparam int LAT = N - 1;
  localparam logic [N-1:0] MINV = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] MAXV = {1'b0, {(N-1){1'b1}}};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          vIn = 1'b0;
  logic [N-1:0]  aIn = '0;
  logic [N-1:0]  xIn = '0;
  logic          vPipe, vComb;
  logic [PW-1:0] pPipe, pComb;

  always #5 clk = ~clk;

  int cycle = 0;
  always @(posedge clk) cycle = cycle + 1;

  bw_mult #(.WIDTH(N), .PIPELINED(1'b1)) uut (
    .clk(clk), .rstN(rstN), .validIn(vIn), .a(aIn), .x(xIn),
    .validOut(vPipe), .p(pPipe)
  );

  bw_mult #(.WIDTH(N), .PIPELINED(1'b0)) uutComb (
    .clk(clk), .rstN(rstN), .validIn(vIn), .a(aIn), .x(xIn),
    .validOut(vComb), .p(pComb)
  );

  typedef struct {
    logic [N-1:0]  a;
    logic [N-1:0]  x;
    logic [PW-1:0] prod;
    int            cyc;
  } item_t;

  item_t qPipe[$];
  item_t qComb[$];
  int total = 0;
  int bad = 0;

  function automatic logic [PW-1:0] refMul(logic [N-1:0] av, logic [N-1:0] xv);
    logic signed [PW-1:0] ea, ex;
    ea = PW'($signed(av));
    ex = PW'($signed(xv));
    return ea * ex;
  endfunction

  function automatic string tagOf(logic [N-1:0] av, logic [N-1:0] xv);
    if (av == '0 || xv == '0) return "R3";
    if ((av == MINV && (xv == MINV || xv == MAXV)) || (xv == MINV && av == MAXV))
      return "R2";
    return "R1";
  endfunction

  task automatic check(bit ok, string tag, string what, logic [PW-1:0] act, logic [PW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(int inst, logic [PW-1:0] pv);
    item_t it;
    int    lat;
    string latTag;
    lat    = (inst == 0) ? LAT : 0;
    latTag = (inst == 0) ? "R5" : "R4";
    if ((inst == 0 && qPipe.size() == 0) || (inst == 1 && qComb.size() == 0)) begin
      check(1'b0, "R7", "validOut without accepted pair", pv, '0);
    end else begin
      it = (inst == 0) ? qPipe.pop_front() : qComb.pop_front();
      check(pv == it.prod, tagOf(it.a, it.x), "product", pv, it.prod);
      check(cycle - it.cyc == lat, latTag, "latency", PW'(cycle - it.cyc), PW'(lat));
      if (it.prod != '0)
        check(pv[PW-1] == (it.a[N-1] ^ it.x[N-1]), "R8", "sign bit",
              PW'(pv[PW-1]), PW'(it.a[N-1] ^ it.x[N-1]));
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (vPipe) compare(0, pPipe);
        if (vComb) compare(1, pComb);
      end
    end
  end

  task automatic drive(logic [N-1:0] av, logic [N-1:0] xv, bit v);
    item_t it;
    @(posedge clk);
    #1;
    aIn = av;
    xIn = xv;
    vIn = v;
    if (v) begin
      it.a = av;
      it.x = xv;
      it.prod = refMul(av, xv);
      it.cyc = cycle;
      qPipe.push_back(it);
      qComb.push_back(it);
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R5 actual=%0d expected=%0d", cycle, 0);
    finishRun();
  end

  initial begin
    // R6: reset holds validOut low
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(vPipe == 1'b0, "R6", "validOut in reset", PW'(vPipe), '0);
    end
    @(posedge clk);
    #1;
    rstN = 1'b1;

    // R7 and R6: operands toggling with validIn low
    for (int k = 0; k < 5; k++) begin
      drive(N'(k * 7 + 3), N'(k * 3 + 1), 1'b0);
      @(negedge clk);
      check(vPipe == 1'b0, "R6", "validOut after reset", PW'(vPipe), '0);
      check(vComb == 1'b0, "R7", "comb validOut while idle", PW'(vComb), '0);
    end

    // Directed corner pairs: R2, R3
    drive(MINV, MINV, 1'b1);
    drive(MINV, MAXV, 1'b1);
    drive(MAXV, MINV, 1'b1);
    drive('0, N'(7), 1'b1);
    drive(N'(9), '0, 1'b1);
    drive('1, '1, 1'b1);
    drive(MAXV, MAXV, 1'b1);

    // Exhaustive back-to-back sweep: R1, R5
    for (int ai = 0; ai < (1 << N); ai++)
      for (int xi = 0; xi < (1 << N); xi++)
        drive(N'(ai), N'(xi), 1'b1);

    // Pairs separated by idle cycles: R5, R7
    for (int k = 0; k < 96; k++)
      drive(N'(k * 5), N'(31 - k), (k % 3) != 0);

    for (int k = 0; k < LAT + 4; k++)
      drive(N'(k), N'(k + 2), 1'b0);
    @(negedge clk);
    check(qPipe.size() == 0, "R5", "pipelined results outstanding", PW'(qPipe.size()), '0);
    check(qComb.size() == 0, "R4", "comb results outstanding", PW'(qComb.size()), '0);

    for (int k = 0; k < 4; k++) begin
      drive(N'(k + 11), N'(k + 17), 1'b0);
      @(negedge clk);
      check(vPipe == 1'b0, "R7", "pipelined validOut while idle", PW'(vPipe), '0);
      check(vComb == 1'b0, "R7", "comb validOut while idle", PW'(vComb), '0);
    end

    finishRun();
  end
endmodule